// File: doc/BRIEF.md
# Chunk Mailbox Filter

A ray-traversal engine hands out leaves of a spatial tree. One scene object is often referenced by many leaves, so the rays of one chunk would test the same object against themselves over and over. This block sits between traversal and the intersection engine and removes those repeats. For each accepted leaf it reads the leaf's object list through a list-cache read port, one word at a time. It compares every object ID against a small mailbox of recently tested IDs and forwards only the IDs it has not seen.

The mailbox belongs to the group of rays that run through the tree together. It is a tiny content-addressed store with first-in first-out replacement, and it is emptied whenever a new chunk begins traversal. Forwarded requests leave on a valid/ready channel. Backpressure on that channel stalls the list walk in place. The block counts forwarded and suppressed IDs so that its filtering rate can be observed.

Top module: `chunk_mailbox_filter`

## Requirements
- R1: After reset, `leaf_ready` is 1, `isect_valid` and `lc_req_valid` are 0, both counters read 0 and the mailbox is empty.
- R2: A leaf at address A stores an unsigned count N (the full data word) at A and the object IDs at A+1 .. A+N. The block issues N+1 single reads with at most one outstanding, and forwards the IDs it does not suppress in list order.
- R3: An ID equal to a valid mailbox entry is not forwarded, and `cnt_suppressed` increases by 1.
- R4: An ID found in no valid entry is presented on `isect_id` with `isect_valid`. On acceptance it is stored in the mailbox, so a repeat later in the same chunk, including one inside the same leaf, is suppressed.
- R5: When the mailbox holds ENTRIES IDs, a new miss replaces the entry that was inserted earliest. A hit does not change the replacement order.
- R6: A one-cycle `chunk_start` invalidates every entry, so each ID met afterwards is forwarded once more.
- R7: A leaf whose count is 0 causes one read, forwards nothing and still completes with a `leaf_done` pulse.
- R8: While `isect_valid` is 1 and `isect_ready` is 0, `isect_valid` and `isect_id` hold their values in the next cycle. No ID is lost or repeated.
- R9: A leaf is accepted only while `leaf_ready` is 1. `leaf_ready` stays 0 until that leaf ends with exactly one `leaf_done` pulse.
- R10: `cnt_forwarded` increases by 1 on every accepted request. The sum of both counters equals the number of IDs processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chunk_start | input | 1 | New ray chunk; clears the mailbox |
| leaf_valid | input | 1 | Leaf request from traversal |
| leaf_ready | output | 1 | Block idle, leaf can be accepted |
| leaf_addr | input | ADDR_W | Address of the leaf's count word |
| leaf_done | output | 1 | One-cycle completion pulse for the leaf |
| lc_req_valid | output | 1 | List-cache read request |
| lc_req_addr | output | ADDR_W | List-cache read address |
| lc_rsp_valid | input | 1 | List-cache read data valid |
| lc_rsp_data | input | ID_W | List-cache read data |
| isect_valid | output | 1 | Intersection request valid |
| isect_ready | input | 1 | Intersection engine accepts |
| isect_id | output | ID_W | Object ID to intersect |
| cnt_suppressed | output | STAT_W | IDs removed as repeats |
| cnt_forwarded | output | STAT_W | IDs forwarded |

## Verification
The bench builds the block with its defaults: a four-entry mailbox, 16-bit IDs and addresses, and 16-bit counters. Four entries are few enough that a run of short leaves overflows the mailbox. This exposes oldest-first eviction, shows that a hit does not refresh an entry, and covers repeats inside one leaf. The list-cache model answers after one to three cycles, and a phase with the intersection side ready only one cycle in three holds requests across several stalled clocks.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
   typedef enum logic [2:0] {
      W_IDLE,
      W_RD_CNT,
      W_WT_CNT,
      W_RD_ID,
      W_WT_ID,
      W_CHK,
      W_FIN
   } walk_st_t;
endpackage

// File: rtl/mbf_tag_store.sv
module mbf_tag_store #(
   parameter int ID_W    = 16,
   parameter int ENTRIES = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            ins,
   input  logic [ID_W-1:0] look_id,
   output logic            hit
);
   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   initial begin
      assert (ENTRIES >= 1 && (ENTRIES & (ENTRIES - 1)) == 0)
         else $error("ENTRIES must be a power of two");
      assert (ID_W >= 1) else $error("ID_W must be positive");
   end

   logic [ENTRIES-1:0] vld;
   logic [ENTRIES-1:0] match;
   logic [ENTRIES-1:0] sel;
   logic [ID_W-1:0]    tag [ENTRIES];

   if (ENTRIES == 1) begin : g_single
      assign sel = 1'b1;
   end else begin : g_ring
      logic [PTR_W-1:0] wptr;
      always_ff @(posedge clk) begin
         if (!rst_n || clear) wptr <= '0;
         else if (ins)        wptr <= wptr + 1'b1;
      end
      assign sel = ENTRIES'(1) << wptr;
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign match[g] = vld[g] && (tag[g] == look_id);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[g] <= 1'b0;
            tag[g] <= '0;
         end else if (clear) begin
            vld[g] <= 1'b0;
         end else if (ins && sel[g]) begin
            vld[g] <= 1'b1;
            tag[g] <= look_id;
         end
      end
   end

   assign hit = |match;

   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (vld == '0)); // R6
   AST_INS_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      ins |-> !hit); // R4
   AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R4
endmodule

// File: rtl/mbf_list_walker.sv
module mbf_list_walker
   import mbf_pkg::*;
#(
   parameter int ID_W   = 16,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              leaf_valid,
   input  logic [ADDR_W-1:0] leaf_addr,
   output logic              leaf_ready,
   output logic              leaf_done,
   output logic              lc_req_valid,
   output logic [ADDR_W-1:0] lc_req_addr,
   input  logic              lc_rsp_valid,
   input  logic [ID_W-1:0]   lc_rsp_data,
   input  logic              hit,
   output logic [ID_W-1:0]   cur_id,
   output logic              isect_valid,
   input  logic              isect_ready,
   output logic              ins,
   output logic              supp_ev
);
   walk_st_t          st;
   logic [ADDR_W-1:0] ptr;
   logic [ID_W-1:0]   remain;
   logic              advance;

   assign leaf_ready   = (st == W_IDLE);
   assign leaf_done    = (st == W_FIN);
   assign lc_req_valid = (st == W_RD_CNT) || (st == W_RD_ID);
   assign lc_req_addr  = ptr;
   assign isect_valid  = (st == W_CHK) && !hit;
   assign ins          = isect_valid && isect_ready;
   assign supp_ev      = (st == W_CHK) && hit;
   assign advance      = ins || supp_ev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= W_IDLE;
         ptr    <= '0;
         remain <= '0;
         cur_id <= '0;
      end else begin
         unique case (st)
            W_IDLE: if (leaf_valid) begin
               ptr <= leaf_addr;
               st  <= W_RD_CNT;
            end
            W_RD_CNT: st <= W_WT_CNT;
            W_WT_CNT: if (lc_rsp_valid) begin
               remain <= lc_rsp_data;
               ptr    <= ptr + ADDR_W'(1);
               st     <= (lc_rsp_data == '0) ? W_FIN : W_RD_ID;
            end
            W_RD_ID: st <= W_WT_ID;
            W_WT_ID: if (lc_rsp_valid) begin
               cur_id <= lc_rsp_data;
               st     <= W_CHK;
            end
            W_CHK: if (advance) begin
               remain <= remain - ID_W'(1);
               ptr    <= ptr + ADDR_W'(1);
               st     <= (remain == ID_W'(1)) ? W_FIN : W_RD_ID;
            end
            W_FIN: st <= W_IDLE;
            default: st <= W_IDLE;
         endcase
      end
   end

   AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      lc_req_valid |=> !lc_req_valid); // R2
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (leaf_valid && leaf_ready) |=> !leaf_ready); // R9
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      leaf_done |=> !leaf_done); // R9
endmodule

// File: rtl/mbf_event_ctr.sv
module mbf_event_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + W'(1);
   end

   AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> (count == $past(count) + W'(1))); // R10
   AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count)); // R10
endmodule

// File: rtl/chunk_mailbox_filter.sv
module chunk_mailbox_filter #(
   parameter int ID_W    = 16,
   parameter int ADDR_W  = 16,
   parameter int ENTRIES = 4,
   parameter int STAT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chunk_start,
   input  logic              leaf_valid,
   output logic              leaf_ready,
   input  logic [ADDR_W-1:0] leaf_addr,
   output logic              leaf_done,
   output logic              lc_req_valid,
   output logic [ADDR_W-1:0] lc_req_addr,
   input  logic              lc_rsp_valid,
   input  logic [ID_W-1:0]   lc_rsp_data,
   output logic              isect_valid,
   input  logic              isect_ready,
   output logic [ID_W-1:0]   isect_id,
   output logic [STAT_W-1:0] cnt_suppressed,
   output logic [STAT_W-1:0] cnt_forwarded
);
   initial begin
      assert (ADDR_W >= 2) else $error("ADDR_W too small");
      assert (STAT_W >= 1) else $error("STAT_W must be positive");
   end

   logic            hit;
   logic            ins;
   logic            supp_ev;
   logic [ID_W-1:0] cur_id;

   mbf_list_walker #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_walk (
      .clk          (clk),
      .rst_n        (rst_n),
      .leaf_valid   (leaf_valid),
      .leaf_addr    (leaf_addr),
      .leaf_ready   (leaf_ready),
      .leaf_done    (leaf_done),
      .lc_req_valid (lc_req_valid),
      .lc_req_addr  (lc_req_addr),
      .lc_rsp_valid (lc_rsp_valid),
      .lc_rsp_data  (lc_rsp_data),
      .hit          (hit),
      .cur_id       (cur_id),
      .isect_valid  (isect_valid),
      .isect_ready  (isect_ready),
      .ins          (ins),
      .supp_ev      (supp_ev)
   );

   mbf_tag_store #(.ID_W(ID_W), .ENTRIES(ENTRIES)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (chunk_start),
      .ins     (ins),
      .look_id (cur_id),
      .hit     (hit)
   );

   mbf_event_ctr #(.W(STAT_W)) u_cnt_supp (
      .clk (clk), .rst_n (rst_n), .inc (supp_ev), .count (cnt_suppressed)
   );

   mbf_event_ctr #(.W(STAT_W)) u_cnt_fwd (
      .clk (clk), .rst_n (rst_n), .inc (ins), .count (cnt_forwarded)
   );

   assign isect_id = cur_id;

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (isect_valid && !isect_ready && !chunk_start) |=> (isect_valid && $stable(isect_id))); // R8
   AST_FWD_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
      (isect_valid && isect_ready) |=> (cnt_forwarded != $past(cnt_forwarded))); // R10
   AST_NO_FWD_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      leaf_ready |-> !isect_valid); // R9
endmodule

// File: tb/sim_chunk_mailbox_filter.sv
`timescale 1ns/1ps
module sim_chunk_mailbox_filter;
   localparam int ID_W    = 16;
   localparam int ADDR_W  = 16;
   localparam int ENTRIES = 4;
   localparam int STAT_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              chunk_start = 1'b0;
   logic              leaf_valid = 1'b0;
   logic              leaf_ready;
   logic [ADDR_W-1:0] leaf_addr = '0;
   logic              leaf_done;
   logic              lc_req_valid;
   logic [ADDR_W-1:0] lc_req_addr;
   logic              lc_rsp_valid = 1'b0;
   logic [ID_W-1:0]   lc_rsp_data = '0;
   logic              isect_valid;
   logic              isect_ready = 1'b1;
   logic [ID_W-1:0]   isect_id;
   logic [STAT_W-1:0] cnt_suppressed;
   logic [STAT_W-1:0] cnt_forwarded;

   chunk_mailbox_filter #(.ID_W(ID_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .STAT_W(STAT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .chunk_start(chunk_start),
      .leaf_valid(leaf_valid), .leaf_ready(leaf_ready), .leaf_addr(leaf_addr),
      .leaf_done(leaf_done), .lc_req_valid(lc_req_valid), .lc_req_addr(lc_req_addr),
      .lc_rsp_valid(lc_rsp_valid), .lc_rsp_data(lc_rsp_data),
      .isect_valid(isect_valid), .isect_ready(isect_ready), .isect_id(isect_id),
      .cnt_suppressed(cnt_suppressed), .cnt_forwarded(cnt_forwarded)
   );

   always #2 clk = ~clk;

   int mem [64];
   int tests = 0, fails = 0;
   int mq[$];
   int expq[$];
   int exp_fwd = 0, exp_supp = 0;
   int done_cnt = 0, lc_reqs = 0;
   int stall_mode = 0, rdy_phase = 0;
   int cd = 0, pend_addr = 0;
   bit stall_seen = 0;
   int stall_id = 0;
   int wd = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // per-clock reference comparison, list-cache model and ready pattern
   always @(negedge clk) begin
      if (rst_n) begin
         lc_rsp_valid = 1'b0;
         if (cd > 0) begin
            cd--;
            if (cd == 0) begin
               lc_rsp_valid = 1'b1;
               lc_rsp_data  = ID_W'(mem[pend_addr]);
            end
         end
         if (lc_req_valid) begin
            lc_reqs++;
            pend_addr = int'(lc_req_addr);
            cd = 1 + (lc_reqs % 3);
         end
         if (leaf_done) done_cnt++;
         rdy_phase++;
         isect_ready = (stall_mode == 0) ? 1'b1 : ((rdy_phase % 3) == 0);
         if (stall_seen)
            chk(isect_valid && int'(isect_id) == stall_id, "R8 held request", int'(isect_id), stall_id);
         stall_seen = isect_valid && !isect_ready;
         stall_id   = int'(isect_id);
         if (isect_valid && expq.size() == 0)
            chk(1'b0, "R3 unexpected forward", int'(isect_id), -1);
         else if (isect_valid && isect_ready) begin
            int e;
            e = expq.pop_front();
            chk(int'(isect_id) == e, "R2 forward order", int'(isect_id), e);
         end
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         fails++;
         $display("FAIL R9 watchdog expired: got %0d expected below 20000", wd);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic model_leaf(input int base);
      int n;
      n = mem[base];
      for (int i = 0; i < n; i++) begin
         int id;
         bit found;
         id = mem[base + 1 + i];
         found = 0;
         foreach (mq[k]) if (mq[k] == id) found = 1;
         if (found) exp_supp++;
         else begin
            expq.push_back(id);
            exp_fwd++;
            mq.push_back(id);
            if (mq.size() > ENTRIES) void'(mq.pop_front());
         end
      end
   endtask

   task automatic run_leaf(input int base, input string tag);
      int d0, r0;
      model_leaf(base);
      d0 = done_cnt;
      r0 = lc_reqs;
      while (!leaf_ready) @(negedge clk);
      leaf_valid = 1'b1;
      leaf_addr  = ADDR_W'(base);
      @(negedge clk);
      leaf_valid = 1'b0;
      chk(!leaf_ready, {tag, " R9 busy after accept"}, int'(leaf_ready), 0);
      while (done_cnt == d0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(done_cnt == d0 + 1, {tag, " R9 one done pulse"}, done_cnt - d0, 1);
      chk(lc_reqs - r0 == mem[base] + 1, {tag, " R2 read count"}, lc_reqs - r0, mem[base] + 1);
      chk(expq.size() == 0, {tag, " R4 all misses forwarded"}, expq.size(), 0);
      chk(int'(cnt_forwarded) == exp_fwd, {tag, " R10 forwarded count"}, int'(cnt_forwarded), exp_fwd);
      chk(int'(cnt_suppressed) == exp_supp, {tag, " R3 suppressed count"}, int'(cnt_suppressed), exp_supp);
   endtask

   task automatic put_leaf(input int base, input int ids[$]);
      mem[base] = ids.size();
      foreach (ids[i]) mem[base + 1 + i] = ids[i];
   endtask

   initial begin
      int f0;
      foreach (mem[i]) mem[i] = 0;
      put_leaf(0,  '{10, 11, 12});
      put_leaf(8,  '{11, 13, 10});
      put_leaf(16, '{14, 10});
      put_leaf(24, '{});
      put_leaf(32, '{20, 20, 20});
      put_leaf(40, '{13, 12});
      put_leaf(44, '{13});
      put_leaf(48, '{30, 31, 32, 33, 34, 35});

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(leaf_ready == 1'b1, "R1 leaf_ready after reset", int'(leaf_ready), 1);
      chk(!isect_valid && !lc_req_valid, "R1 idle outputs", int'(isect_valid), 0);
      chk(cnt_forwarded == 0 && cnt_suppressed == 0, "R1 counters zero", int'(cnt_forwarded), 0);

      run_leaf(0, "R1 fresh mailbox");
      run_leaf(8, "R3 hits");
      run_leaf(16, "R5 eviction");
      f0 = int'(cnt_forwarded);
      run_leaf(24, "R7 empty leaf");
      chk(int'(cnt_forwarded) == f0, "R7 nothing forwarded", int'(cnt_forwarded), f0);
      run_leaf(32, "R4 repeat inside leaf");
      run_leaf(40, "R5 hit keeps order");
      f0 = int'(cnt_forwarded);
      run_leaf(44, "R5 oldest evicted");
      chk(int'(cnt_forwarded) == f0 + 1, "R5 evicted id forwarded again", int'(cnt_forwarded) - f0, 1);

      chunk_start = 1'b1;
      @(negedge clk);
      chunk_start = 1'b0;
      mq.delete();
      f0 = int'(cnt_forwarded);
      run_leaf(0, "R6 after chunk start");
      chk(int'(cnt_forwarded) == f0 + 3, "R6 all ids forwarded", int'(cnt_forwarded) - f0, 3);

      stall_mode = 1;
      run_leaf(48, "R8 stalled walk");
      run_leaf(8, "R8 stalled mixed");
      stall_mode = 0;
      chk(int'(cnt_forwarded) + int'(cnt_suppressed) == exp_fwd + exp_supp,
          "R10 totals", int'(cnt_forwarded) + int'(cnt_suppressed), exp_fwd + exp_supp);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule